// File: doc/BRIEF.md
# Flag-setting 32-bit data-processing ALU

This block is the execute stage of a small load/store processor's data-processing path. Each cycle it takes a first operand from a register and a second operand, and applies one of sixteen operations chosen by a 4-bit code. The second operand is either a register value or an 8-bit immediate zero-extended to full width. The result is produced combinationally. A destination write-enable tells the register file whether the result is to be stored.

A four-bit status register holds the negative, zero, carry and overflow flags. It loads on the rising clock edge only when the clock enable and the set-flags control are both high. The carry flag feeds the carry-using add and subtract forms. For every subtract, the carry flag means "no borrow". Four compare and test forms update the flags and never request a register write.

Top module: `dp_alu`

## Requirements
- R1: The logical codes give AND=0 rn&op2, EOR=1 rn^op2, ORR=C rn|op2, MOV=D op2, BIC=E rn&~op2 and MVN=F ~op2 on `result`, and `wr_en` is high while `en` is high.
- R2: SUB=2 gives rn-op2, RSB=3 gives op2-rn and ADD=4 gives rn+op2, each modulo 2^32, and `wr_en` is high while `en` is high.
- R3: ADC=5 gives rn+op2+C, SBC=6 gives rn-op2-(1-C) and RSC=7 gives op2-rn-(1-C). C is the stored carry flag `flags[1]`.
- R4: TST=8 (AND), TEQ=9 (XOR), CMP=A (rn-op2) and CMN=B (rn+op2) keep `wr_en` low. With set-flags high, they update the flags exactly as the matching operation would.
- R5: After an addition form, C becomes the carry out of bit 31. After a subtraction form, C becomes 1 when no borrow occurs (the subtrahend plus any borrow-in is not larger than the minuend, unsigned), and 0 otherwise.
- R6: On every flag update, Z (`flags[2]`) becomes 1 exactly when the 32-bit result is zero, and N (`flags[3]`) becomes result bit 31.
- R7: After an arithmetic form, V (`flags[0]`) becomes 1 exactly when the signed two's-complement result overflows.
- R8: A flag update by a logical form (codes 0, 1, 8, 9, C, D, E, F) leaves C and V unchanged.
- R9: With `use_imm` high, op2 is `imm` zero-extended to 32 bits, and `op2_reg` is ignored.
- R10: The flags load on the rising clock edge only when `en` and `set_flags` are both high, and otherwise hold their value. `wr_en` is low whenever `en` is low.
- R11: While `rst_n` is low, all four flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset of the flags |
| en | input | 1 | Clock enable: the operation is valid this cycle |
| set_flags | input | 1 | Load the flags from this operation |
| opcode | input | 4 | Operation code |
| rn | input | 32 | First operand |
| op2_reg | input | 32 | Register second operand |
| imm | input | 8 | Immediate second operand |
| use_imm | input | 1 | Select the immediate as second operand |
| result | output | 32 | Operation result |
| wr_en | output | 1 | Destination register write request |
| flags | output | 4 | Stored flags {N, Z, C, V} |

## Verification
The checker assumes the inputs are settled before each rising edge and carry no unknown values. It also assumes that the `result` seen at an edge is the value the flags are computed from. The bench changes inputs only on falling edges and holds them for a full cycle, so each flag check sees a single stable operation. The carry-using forms are driven once with the carry set and once with it clear. The stored carry is placed first by a preceding flag-setting operation.

// File: rtl/dp_alu.sv
module dp_alu #(
  parameter int W     = 32,
  parameter int IMM_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             set_flags,
  input  logic [3:0]       opcode,
  input  logic [W-1:0]     rn,
  input  logic [W-1:0]     op2_reg,
  input  logic [IMM_W-1:0] imm,
  input  logic             use_imm,
  output logic [W-1:0]     result,
  output logic             wr_en,
  output logic [3:0]       flags
);
  localparam logic [3:0] OP_AND = 4'h0, OP_EOR = 4'h1, OP_SUB = 4'h2, OP_RSB = 4'h3,
                         OP_ADD = 4'h4, OP_ADC = 4'h5, OP_SBC = 4'h6, OP_RSC = 4'h7,
                         OP_TST = 4'h8, OP_TEQ = 4'h9, OP_CMP = 4'hA, OP_CMN = 4'hB,
                         OP_ORR = 4'hC, OP_MOV = 4'hD, OP_BIC = 4'hE, OP_MVN = 4'hF;

  logic [W-1:0] op2;
  logic [W-1:0] add_a, add_b;
  logic         add_cin;
  logic [W:0]   sum;
  logic         arith;
  logic         cflag;
  logic         n_nxt, z_nxt, c_nxt, v_nxt;

  assign op2   = use_imm ? {{(W-IMM_W){1'b0}}, imm} : op2_reg;
  assign cflag = flags[1];

  always_comb begin
    arith   = 1'b1;
    add_a   = rn;
    add_b   = op2;
    add_cin = 1'b0;
    unique case (opcode)
      OP_SUB, OP_CMP: begin add_b = ~op2; add_cin = 1'b1; end
      OP_RSB:         begin add_a = op2; add_b = ~rn; add_cin = 1'b1; end
      OP_ADD, OP_CMN: ;
      OP_ADC:         add_cin = cflag;
      OP_SBC:         begin add_b = ~op2; add_cin = cflag; end
      OP_RSC:         begin add_a = op2; add_b = ~rn; add_cin = cflag; end
      default:        arith = 1'b0;
    endcase
  end

  assign sum = {1'b0, add_a} + {1'b0, add_b} + {{W{1'b0}}, add_cin};

  always_comb begin
    unique case (opcode)
      OP_AND, OP_TST: result = rn & op2;
      OP_EOR, OP_TEQ: result = rn ^ op2;
      OP_ORR:         result = rn | op2;
      OP_MOV:         result = op2;
      OP_BIC:         result = rn & ~op2;
      OP_MVN:         result = ~op2;
      default:        result = sum[W-1:0];
    endcase
  end

  assign wr_en = en && (opcode[3:2] != 2'b10);

  assign n_nxt = result[W-1];
  assign z_nxt = (result == '0);
  assign c_nxt = arith ? sum[W] : flags[1];
  assign v_nxt = arith ? ((add_a[W-1] == add_b[W-1]) && (sum[W-1] != add_a[W-1])) : flags[0];

  always_ff @(posedge clk) begin
    if (!rst_n)               flags <= 4'b0000;
    else if (en && set_flags) flags <= {n_nxt, z_nxt, c_nxt, v_nxt};
  end
endmodule

// File: rtl/dp_alu_chk.sv
module dp_alu_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        en,
  input logic        set_flags,
  input logic [3:0]  opcode,
  input logic [31:0] rn,
  input logic [31:0] op2_reg,
  input logic [7:0]  imm,
  input logic        use_imm,
  input logic [31:0] result,
  input logic        wr_en,
  input logic [3:0]  flags
);
  logic logical_op;
  assign logical_op = (opcode < 4'h2) || (opcode == 4'h8) || (opcode == 4'h9) || (opcode >= 4'hC);

  AST_CMP_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (opcode[3:2] == 2'b10) |-> !wr_en); // R4
  AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !wr_en); // R10
  AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(en && set_flags) |=> $stable(flags)); // R10
  AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (en && set_flags) |=> (flags[2] == ($past(result) == 32'h0))); // R6
  AST_NEG_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (en && set_flags) |=> (flags[3] == $past(result[31]))); // R6
  AST_LOGIC_KEEPS_CV: assert property (@(posedge clk) disable iff (!rst_n)
    (en && set_flags && logical_op) |=> (flags[1:0] == $past(flags[1:0]))); // R8
  AST_IMM_ZERO_EXT: assert property (@(posedge clk) disable iff (!rst_n)
    (use_imm && opcode == 4'hD) |-> (result == {24'h0, imm})); // R9
  AST_RESET_CLEAR: assert property (@(posedge clk)
    !rst_n |=> (flags == 4'b0000)); // R11
endmodule

bind dp_alu dp_alu_chk chk (.*);

// File: tb/dp_alu_test.sv
module dp_alu_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        en = 0, set_flags = 0, use_imm = 0;
  logic [3:0]  opcode = 0;
  logic [31:0] rn = 0, op2_reg = 0;
  logic [7:0]  imm = 0;
  logic [31:0] result;
  logic        wr_en;
  logic [3:0]  flags;

  int checks = 0, failures = 0;
  bit finished = 0;
  logic [3:0] exp_flags = 0;

  always #4 clk = ~clk;

  dp_alu uut (.clk, .rst_n, .en, .set_flags, .opcode, .rn, .op2_reg, .imm, .use_imm,
              .result, .wr_en, .flags);

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic step(string req, logic [3:0] op, logic [31:0] a, logic [31:0] b,
                      logic ui, logic [7:0] im, logic s, logic e);
    logic [31:0] bb, r;
    logic        c, v, ar, cin;
    longint      sa, sb, sr;
    @(negedge clk);
    opcode = op; rn = a; op2_reg = b; use_imm = ui; imm = im; set_flags = s; en = e;
    bb  = ui ? {24'h0, im} : b;
    cin = exp_flags[1];
    sa  = longint'($signed(a)); sb = longint'($signed(bb));
    ar  = 1; c = 0; sr = 0;
    case (op)
      4'h0, 4'h8: begin r = a & bb; ar = 0; end
      4'h1, 4'h9: begin r = a ^ bb; ar = 0; end
      4'hC: begin r = a | bb; ar = 0; end
      4'hD: begin r = bb; ar = 0; end
      4'hE: begin r = a & ~bb; ar = 0; end
      4'hF: begin r = ~bb; ar = 0; end
      4'h2, 4'hA: begin r = a - bb; c = (a >= bb); sr = sa - sb; end
      4'h3: begin r = bb - a; c = (bb >= a); sr = sb - sa; end
      4'h4, 4'hB: begin r = a + bb; c = ({1'b0, a} + {1'b0, bb}) > 33'hFFFFFFFF; sr = sa + sb; end
      4'h5: begin r = a + bb + cin; c = ({1'b0, a} + {1'b0, bb} + cin) > 33'hFFFFFFFF; sr = sa + sb + cin; end
      4'h6: begin r = a - bb - !cin; c = {1'b0, a} >= ({1'b0, bb} + !cin); sr = sa - sb - !cin; end
      default: begin r = bb - a - !cin; c = {1'b0, bb} >= ({1'b0, a} + !cin); sr = sb - sa - !cin; end
    endcase
    v = ar && (sr != longint'($signed(r)));
    #1;
    check(req, "result", result, r);
    check(req, "wr_en", {31'h0, wr_en}, {31'h0, e && (op[3:2] != 2'b10)});
    if (e && s) exp_flags = {r[31], r == 0, ar ? c : exp_flags[1], ar ? v : exp_flags[0]};
    @(posedge clk); #1;
    check(req, "flags", {28'h0, flags}, {28'h0, exp_flags});
  endtask

  task automatic t_reset;
    @(negedge clk); #1;
    check("R11", "flags in reset", {28'h0, flags}, 32'h0);
    rst_n = 1;
  endtask

  task automatic t_logic;
    step("R1", 4'h0, 32'hF0F0_1234, 32'h0FF0_FF00, 0, 0, 1, 1);
    step("R1", 4'h1, 32'hAAAA_5555, 32'hFFFF_0000, 0, 0, 1, 1);
    step("R1", 4'hC, 32'h1200_0034, 32'h0056_7800, 0, 0, 0, 1);
    step("R1", 4'hD, 32'h0, 32'h8000_0001, 0, 0, 1, 1);
    step("R1", 4'hE, 32'hFFFF_FFFF, 32'h0000_FFFF, 0, 0, 1, 1);
    step("R1", 4'hF, 32'h0, 32'h0000_0000, 0, 0, 1, 1);
  endtask

  task automatic t_arith;
    step("R2", 4'h2, 32'd95, 32'd23, 0, 0, 1, 1);
    step("R2", 4'h3, 32'd100, 32'd7, 0, 0, 1, 1);
    step("R2", 4'h4, 32'd19, 32'd95, 0, 0, 1, 1);
  endtask

  task automatic t_carry;
    step("R3", 4'h4, 32'hFFFF_FFFF, 32'd1, 0, 0, 1, 1);
    step("R3", 4'h5, 32'd10, 32'd20, 0, 0, 1, 1);
    step("R3", 4'h6, 32'd10, 32'd3, 0, 0, 1, 1);
    step("R3", 4'h6, 32'd10, 32'd3, 0, 0, 1, 1);
    step("R3", 4'h7, 32'd5, 32'd9, 0, 0, 1, 1);
    step("R3", 4'h2, 32'd1, 32'd2, 0, 0, 1, 1);
    step("R3", 4'h5, 32'd10, 32'd20, 0, 0, 1, 1);
    step("R3", 4'h7, 32'd5, 32'd9, 0, 0, 1, 1);
  endtask

  task automatic t_compare;
    step("R4", 4'hA, 32'h9C, 32'h9C, 0, 0, 1, 1);
    step("R4", 4'hB, 32'h9C, 32'hFFFF_FF64, 0, 0, 1, 1);
    step("R4", 4'h8, 32'hF0, 32'h0F, 0, 0, 1, 1);
    step("R4", 4'h9, 32'h8000_0000, 32'h1, 0, 0, 1, 1);
  endtask

  task automatic t_cflag;
    step("R5", 4'h2, 32'h52, 32'h73, 0, 0, 1, 1);
    step("R5", 4'h2, 32'hA5, 32'h23, 0, 0, 1, 1);
    step("R5", 4'h4, 32'h8000_0000, 32'h8000_0000, 0, 0, 1, 1);
  endtask

  task automatic t_zn;
    step("R6", 4'h3, 32'd5, 32'd5, 0, 0, 1, 1);
    step("R6", 4'hD, 32'h0, 32'hFFFF_FFFE, 0, 0, 1, 1);
  endtask

  task automatic t_overflow;
    step("R7", 4'h4, 32'h7FFF_FFFF, 32'd1, 0, 0, 1, 1);
    step("R7", 4'h2, 32'h8000_0000, 32'd1, 0, 0, 1, 1);
    step("R7", 4'h4, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, 0, 1, 1);
  endtask

  task automatic t_logic_keeps_cv;
    step("R8", 4'h4, 32'h7FFF_FFFF, 32'h8000_0001, 0, 0, 1, 1);
    step("R8", 4'h4, 32'h7FFF_FFFF, 32'd1, 0, 0, 1, 1);
    step("R8", 4'h0, 32'h0, 32'h0, 0, 0, 1, 1);
    step("R8", 4'h9, 32'h1, 32'h3, 0, 0, 1, 1);
  endtask

  task automatic t_imm;
    step("R9", 4'hD, 32'h0, 32'hDEAD_BEEF, 1, 8'hFF, 1, 1);
    step("R9", 4'h4, 32'h100, 32'hFFFF_FFFF, 1, 8'h80, 1, 1);
  endtask

  task automatic t_hold;
    step("R10", 4'h2, 32'd3, 32'd3, 0, 0, 0, 1);
    step("R10", 4'h4, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, 0, 1, 0);
    step("R10", 4'h2, 32'd0, 32'd1, 0, 0, 1, 1);
    step("R10", 4'hC, 32'd0, 32'd0, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    t_reset();
    t_logic();
    t_arith();
    t_carry();
    t_compare();
    t_cflag();
    t_zn();
    t_overflow();
    t_logic_keeps_cv();
    t_imm();
    t_hold();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #200000;
    if (!finished) begin
      checks++; failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule